// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block sits beside the command sequencer of a synchronous DRAM controller or device model. It holds the burst part of the mode-register key, decodes it into a burst length and a beat order, and supplies one column address per data beat once a column command starts a burst. The beats wrap inside an aligned block whose size is the burst length, except in full-page mode, where the address runs over the whole 512-column row and wraps until something ends the burst.

A start strobe with a 9-bit starting column begins a burst. The per-cycle advance enable models clock suspension: while it is low, the block freezes and ignores its command inputs. A stop input, or a new start, ends the current burst at once. Outputs are the column address, a beat-valid flag, a last-beat flag and a flag for a mode key that is not legal.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, beat_valid, last_beat and mode_err are 0, and the burst setting is length 1 with sequential order.
- R2: A mode_load cycle captures mode_key: bits 2..0 give the length code (000=1, 001=2, 010=4, 011=8 beats) and bit 3 gives the order (0 sequential, 1 interleave); bits 6..4 hold the latency field, which this block does not use.
- R3: In the cycle after an accepted start, beat_valid is 1 and col_addr equals start_col.
- R4: In sequential order, beat i keeps the column bits above log2(BL) from start_col, and its low log2(BL) bits are (start low bits + i) mod BL.
- R5: In interleave order, the low log2(BL) bits of beat i are the start low bits XOR i, and the upper bits stay fixed.
- R6: last_beat is 1 only on beat BL-1; in the cycle after it, with no new start, beat_valid is 0.
- R7: Length code 111 with sequential order selects full page: beat i is (start_col + i) mod 512, last_beat never rises, and the burst runs until stop or a new start.
- R8: Length codes 100, 101, 110, code 111 with interleave, or any 1 in key bits 11..7 set mode_err to 1, and the burst is then one beat long.
- R9: While advance is 0, col_addr, beat_valid and the beat position hold their values, and start and stop in that cycle are ignored.
- R10: A stop accepted during a burst makes beat_valid 0 in the next cycle.
- R11: A start accepted during a burst restarts at beat 0 of the new start_col in the next cycle, and it wins over a stop in the same cycle.
- R12: Loading a legal key clears mode_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mode_load | input | 1 | Capture mode_key this cycle |
| mode_key | input | 12 | Packed mode-register key |
| advance | input | 1 | Clock enable; 0 suspends the block |
| start | input | 1 | Column command: begin a burst |
| start_col | input | 9 | Starting column of the burst |
| stop | input | 1 | Burst stop: end the current burst |
| col_addr | output | 9 | Column address of the current beat |
| beat_valid | output | 1 | A burst beat is present |
| last_beat | output | 1 | Current beat is the final one of a fixed burst |
| mode_err | output | 1 | Held key is reserved or not legal |

## Verification
The hardest situation to reach is the full-page wrap: a burst has to run past column 511 back through column 0 without a last-beat flag and still stop on command. The stimulus starts a full-page burst two columns below the top of the row and follows it for more than a full row before stopping it. Clock suspension in the middle of a burst, with a stop held in the frozen cycles, and a restart that arrives together with a stop are driven in their own directed scenarios.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

    localparam int COL_W   = 9;
    localparam int KEY_W   = 12;
    localparam int CODE_W  = 3;
    localparam int ORD_BIT = 3;
    localparam int KEY_TOP_USED = 6;

    typedef enum logic {
        ORD_SEQ   = 1'b0,
        ORD_INTLV = 1'b1
    } beat_order_e;

    typedef struct packed {
        logic              full_page;
        beat_order_e       order;
        logic [COL_W-1:0]  last_idx;
    } burst_cfg_t;

    localparam burst_cfg_t CFG_RESET = '{full_page: 1'b0, order: ORD_SEQ, last_idx: '0};

    function automatic logic [COL_W-1:0] len_mask(input logic [CODE_W-1:0] code);
        logic [COL_W-1:0] m;
        m = '0;
        for (int b = 0; b < COL_W; b++) begin
            if (b < int'(code)) m[b] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/burst_mode_reg.sv
module burst_mode_reg
    import burst_col_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [KEY_W-1:0] key,
    output burst_cfg_t       cfg,
    output logic             err
);

    logic [CODE_W-1:0] code;
    beat_order_e       ord;
    logic              upper_set;
    burst_cfg_t        dec_cfg;
    logic              dec_bad;

    assign code      = key[CODE_W-1:0];
    assign ord       = beat_order_e'(key[ORD_BIT]);
    assign upper_set = |key[KEY_W-1:KEY_TOP_USED+1];

    always_comb begin
        dec_cfg.full_page = 1'b0;
        dec_cfg.order     = ord;
        dec_cfg.last_idx  = '0;
        dec_bad           = upper_set;
        case (code)
            3'b000, 3'b001, 3'b010, 3'b011: dec_cfg.last_idx = len_mask(code);
            3'b111: begin
                if (ord == ORD_SEQ) begin
                    dec_cfg.full_page = 1'b1;
                    dec_cfg.last_idx  = '1;
                end else begin
                    dec_bad = 1'b1;
                end
            end
            default: dec_bad = 1'b1;
        endcase
        if (dec_bad) begin
            dec_cfg.full_page = 1'b0;
            dec_cfg.last_idx  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= CFG_RESET;
            err <= 1'b0;
        end else if (load) begin
            cfg <= dec_cfg;
            err <= dec_bad;
        end
    end

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
    import burst_col_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    input  logic             start,
    input  logic             stop,
    input  logic [COL_W-1:0] start_col,
    input  burst_cfg_t       cfg,
    output logic             active,
    output logic [COL_W-1:0] base,
    output logic [COL_W-1:0] beat,
    output logic             last
);

    assign last = active && !cfg.full_page && (beat >= cfg.last_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            base   <= '0;
            beat   <= '0;
        end else if (advance) begin
            if (start) begin
                active <= 1'b1;
                base   <= start_col;
                beat   <= '0;
            end else if (stop) begin
                active <= 1'b0;
            end else if (active) begin
                if (last) active <= 1'b0;
                else      beat   <= beat + 1'b1;
            end
        end
    end

endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map
    import burst_col_pkg::*;
(
    input  burst_cfg_t       cfg,
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] beat,
    output logic [COL_W-1:0] addr
);

    logic [COL_W-1:0] blk_mask;
    logic [COL_W-1:0] low_part;

    assign blk_mask = cfg.full_page ? '1 : cfg.last_idx;

    always_comb begin
        if (cfg.order == ORD_INTLV) low_part = base ^ beat;
        else                        low_part = base + beat;
        addr = (base & ~blk_mask) | (low_part & blk_mask);
    end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import burst_col_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_load,
    input  logic [KEY_W-1:0] mode_key,
    input  logic             advance,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic             stop,
    output logic [COL_W-1:0] col_addr,
    output logic             beat_valid,
    output logic             last_beat,
    output logic             mode_err
);

    burst_cfg_t       cfg;
    logic [COL_W-1:0] base;
    logic [COL_W-1:0] beat;

    burst_mode_reg u_mode (
        .clk  (clk),
        .rst  (rst),
        .load (mode_load),
        .key  (mode_key),
        .cfg  (cfg),
        .err  (mode_err)
    );

    burst_beat_ctr u_ctr (
        .clk       (clk),
        .rst       (rst),
        .advance   (advance),
        .start     (start),
        .stop      (stop),
        .start_col (start_col),
        .cfg       (cfg),
        .active    (beat_valid),
        .base      (base),
        .beat      (beat),
        .last      (last_beat)
    );

    burst_addr_map u_map (
        .cfg  (cfg),
        .base (base),
        .beat (beat),
        .addr (col_addr)
    );

endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk
    import burst_col_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             mode_load,
    input logic             advance,
    input logic             start,
    input logic [COL_W-1:0] start_col,
    input logic             stop,
    input logic [COL_W-1:0] col_addr,
    input logic             beat_valid,
    input logic             last_beat
);

    p_start_beat0_r3: assert property (@(posedge clk) disable iff (rst)
        (advance && start) |=> (beat_valid && col_addr == $past(start_col)));

    p_last_in_burst_r6: assert property (@(posedge clk) disable iff (rst)
        last_beat |-> beat_valid);

    p_last_ends_r6: assert property (@(posedge clk) disable iff (rst)
        (advance && last_beat && !start) |=> !beat_valid);

    p_suspend_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && !advance && !mode_load) |=> (beat_valid && $stable(col_addr)));

    p_stop_ends_r10: assert property (@(posedge clk) disable iff (rst)
        (advance && stop && !start) |=> !beat_valid);

endmodule

bind burst_col_gen burst_col_gen_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .mode_load  (mode_load),
    .advance    (advance),
    .start      (start),
    .start_col  (start_col),
    .stop       (stop),
    .col_addr   (col_addr),
    .beat_valid (beat_valid),
    .last_beat  (last_beat)
);

// File: tb/burst_col_gen_test.sv
module burst_col_gen_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_load = 1'b0;
    logic [11:0] mode_key = '0;
    logic        advance = 1'b1;
    logic        start = 1'b0;
    logic [8:0]  start_col = '0;
    logic        stop = 1'b0;
    logic [8:0]  col_addr;
    logic        beat_valid;
    logic        last_beat;
    logic        mode_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    burst_col_gen uut (
        .clk(clk), .rst(rst), .mode_load(mode_load), .mode_key(mode_key),
        .advance(advance), .start(start), .start_col(start_col), .stop(stop),
        .col_addr(col_addr), .beat_valid(beat_valid), .last_beat(last_beat),
        .mode_err(mode_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int exp_addr(input int base, input int i, input int bl, input bit intlv);
        int m, lo;
        if (bl == 512) return (base + i) % 512;
        m  = bl - 1;
        lo = intlv ? ((base ^ i) & m) : ((base + i) & m);
        return (base & ~m & 511) | lo;
    endfunction

    task automatic load_mode(input logic [2:0] code, input bit intlv, input logic [4:0] upper);
        @(negedge clk);
        mode_load = 1'b1;
        mode_key  = {upper, 3'b010, intlv, code};
        @(negedge clk);
        mode_load = 1'b0;
    endtask

    task automatic begin_burst(input int col);
        @(negedge clk);
        start     = 1'b1;
        start_col = 9'(col);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_burst(input string req, input int col, input int bl, input bit intlv);
        begin_burst(col);
        for (int i = 0; i < bl; i++) begin
            if (i > 0) @(negedge clk);
            chk(req, int'(beat_valid), 1);
            chk(req, int'(col_addr), exp_addr(col, i, bl, intlv));
            chk({req, " last"}, int'(last_beat), (i == bl - 1) ? 1 : 0);
        end
        @(negedge clk);
        chk({req, " end R6"}, int'(beat_valid), 0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 valid", int'(beat_valid), 0);
        chk("R1 last", int'(last_beat), 0);
        chk("R1 err", int'(mode_err), 0);
        run_burst("R1 default BL1", 9'h0AB, 1, 1'b0);
    endtask

    task automatic t_seq();
        load_mode(3'b011, 1'b0, 5'd0);
        chk("R2 err", int'(mode_err), 0);
        run_burst("R4 seq BL8", 9'h0D5, 8, 1'b0);
        load_mode(3'b001, 1'b0, 5'd0);
        run_burst("R4 seq BL2", 9'h13F, 2, 1'b0);
    endtask

    task automatic t_intlv();
        load_mode(3'b010, 1'b1, 5'd0);
        run_burst("R5 intlv BL4", 9'h1A6, 4, 1'b1);
        load_mode(3'b011, 1'b1, 5'd0);
        run_burst("R5 intlv BL8", 9'h05B, 8, 1'b1);
    endtask

    task automatic t_full();
        int seen_last = 0;
        load_mode(3'b111, 1'b0, 5'd0);
        chk("R7 err", int'(mode_err), 0);
        begin_burst(9'h1FE);
        for (int i = 0; i < 520; i++) begin
            if (i > 0) @(negedge clk);
            if (last_beat) seen_last++;
            if (i < 4 || i == 519) begin
                chk("R7 full addr", int'(col_addr), exp_addr(9'h1FE, i, 512, 1'b0));
                chk("R7 full valid", int'(beat_valid), 1);
            end
        end
        chk("R7 no last", seen_last, 0);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        chk("R10 stop full", int'(beat_valid), 0);
    endtask

    task automatic t_reserved();
        load_mode(3'b101, 1'b0, 5'd0);
        chk("R8 code101 err", int'(mode_err), 1);
        run_burst("R8 code101 len1", 9'h033, 1, 1'b0);
        load_mode(3'b111, 1'b1, 5'd0);
        chk("R8 fullpage intlv err", int'(mode_err), 1);
        run_burst("R8 fp intlv len1", 9'h101, 1, 1'b0);
        load_mode(3'b010, 1'b0, 5'b10000);
        chk("R8 upper bits err", int'(mode_err), 1);
        run_burst("R8 upper len1", 9'h0F2, 1, 1'b0);
        load_mode(3'b010, 1'b0, 5'd0);
        chk("R12 err cleared", int'(mode_err), 0);
    endtask

    task automatic t_suspend();
        load_mode(3'b010, 1'b0, 5'd0);
        begin_burst(9'h012);
        chk("R9 beat0", int'(col_addr), 9'h012);
        advance = 1'b0;
        stop    = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9 hold addr", int'(col_addr), 9'h012);
        chk("R9 hold valid", int'(beat_valid), 1);
        advance = 1'b1;
        stop    = 1'b0;
        @(negedge clk);
        chk("R9 resume beat1", int'(col_addr), 9'h013);
        @(negedge clk);
        chk("R9 beat2", int'(col_addr), 9'h010);
        @(negedge clk);
        chk("R9 beat3 last", int'(last_beat), 1);
        @(negedge clk);
        chk("R9 done", int'(beat_valid), 0);
    endtask

    task automatic t_stop_restart();
        load_mode(3'b011, 1'b0, 5'd0);
        begin_burst(9'h020);
        @(negedge clk);
        chk("R10 beat1", int'(col_addr), 9'h021);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        chk("R10 stopped", int'(beat_valid), 0);
        begin_burst(9'h020);
        repeat (2) @(negedge clk);
        start = 1'b1; stop = 1'b1; start_col = 9'h045;
        @(negedge clk);
        start = 1'b0; stop = 1'b0;
        chk("R11 restart valid", int'(beat_valid), 1);
        chk("R11 restart addr", int'(col_addr), 9'h045);
        chk("R11 restart not last", int'(last_beat), 0);
        @(negedge clk);
        chk("R11 next beat", int'(col_addr), 9'h046);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        chk("R10 stop again", int'(beat_valid), 0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_seq();
        t_intlv();
        t_full();
        t_reserved();
        t_suspend();
        t_stop_restart();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule